// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects the single-cycle event strobes of a power-management device into five 16-bit secondary status banks and combines them into one active-low, level-sensitive interrupt line for the host. Each bank has a companion enable mask. A mask bit of 1 blocks a source and a 0 passes it. A latched status bit stays set until software writes a 1 to its position. Any bank's bits can feed several functional groups, and the undervoltage group draws on two banks.

The unmasked status bits are reduced into a 16-bit group summary. A top-level summary mask decides which groups may drive the line. Software reaches every register through a plain synchronous port: address, write data, write enable, read enable, and read data that is registered one cycle after the read. The bridge to a serial bus and the event sources themselves sit outside this block.

Top module: `pmu_irq_top`

## Requirements
- R1: After reset, all five bank masks and the summary mask read 0xFFFF, all status banks and the summary read 0x0000, and irq_n is 1.
- R2: A one-cycle strobe on src_evt[16*b+k] (b = bank 0..4, k = bit) sets status bit k of bank b at the next clock edge, and the bit holds until it is cleared. Bits that no source uses (bank 0 bit 15, bank 1 bits 15..10, bank 2 bits 15..10, bank 3 bits 15..6) always read 0.
- R3: Writing a status bank sets to 0 every bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A status bit whose mask bit is 1 still latches, but it adds nothing to the summary and nothing to irq_n.
- R6: Bank 0 groups, with summary bit in brackets: thermal bit0 [0], on-key bit1 [1], power path bits 4..2 [2], watchdog bit5 [3], clock/alarm bits 7..6 [4], touch sample bit8 [5], pen-down bit9 [6], converter/comparators bits 14..10 [7].
- R7: Bank 1 bits 7..0 (charger) feed summary bit 8 and bank 1 bits 9..8 (current sink) feed bit 9. All sixteen bits of bank 4 (general I/O) feed summary bit 12.
- R8: Summary bit 10 (undervoltage) is the OR of unmasked bank 2 bits 9..0 and bank 3 bits 3..0. Bank 3 bits 5..4 (high current) feed summary bit 11 only.
- R9: A summary-mask bit of 1 keeps its group off irq_n. The summary register itself reads the group state before that mask.
- R10: irq_n goes to 0 one clock after any group is pending and not masked at the top, stays 0 while that holds, and returns to 1 one clock after it stops.
- R11: Address map: 0x00 summary (read only), 0x01 summary mask, 0x08+b status of bank b, 0x10+b mask of bank b. bus_rdata shows the addressed register one clock after bus_re, and a write decodes to at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 80 | Event strobes, bit 16*bank+bit |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The assertions check on every clock edge that a strobe beats a clear, that written-one bits clear and untouched bits hold, that the line follows the gated pending state one cycle later, that a summary bit never appears without some unmasked status bit behind it, and that a write selects at most one register. The group routing can only be shown by the bench's scenarios: each source bit lights exactly its expected summary bit, and the undervoltage group is reached from two banks. The bench also covers reset values, read latency, and the difference between the summary readback and the top-gated line.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_SEC = 5;
  localparam int GRP_W   = 16;
  localparam int NUM_GRP = 13;
  localparam int ADDR_W  = 5;
  localparam int SRC_W   = NUM_SEC * REG_W;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 5'h00;
  localparam logic [ADDR_W-1:0] A_TOPMASK = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT0   = 5'h08;
  localparam logic [ADDR_W-1:0] A_MASK0   = 5'h10;

  typedef enum logic [3:0] {
    G_THERM = 4'd0, G_ONKEY = 4'd1, G_PPATH = 4'd2, G_WDOG = 4'd3,
    G_CLOCK = 4'd4, G_TSAMP = 4'd5, G_TPEN = 4'd6, G_CONV = 4'd7,
    G_CHG = 4'd8, G_SINK = 4'd9, G_UVOLT = 4'd10, G_HICUR = 4'd11,
    G_GPIO = 4'd12
  } grp_e;

  // Bits of a bank that have a source behind them.
  function automatic logic [REG_W-1:0] impl_bits(input int bank);
    case (bank)
      0:       return 16'h7FFF;
      1:       return 16'h03FF;
      2:       return 16'h03FF;
      3:       return 16'h003F;
      4:       return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  // Which bits of a bank feed a summary group.
  function automatic logic [REG_W-1:0] grp_bits(input int grp, input int bank);
    logic [REG_W-1:0] m;
    m = '0;
    case (grp)
      G_THERM: if (bank == 0) m = 16'h0001;
      G_ONKEY: if (bank == 0) m = 16'h0002;
      G_PPATH: if (bank == 0) m = 16'h001C;
      G_WDOG:  if (bank == 0) m = 16'h0020;
      G_CLOCK: if (bank == 0) m = 16'h00C0;
      G_TSAMP: if (bank == 0) m = 16'h0100;
      G_TPEN:  if (bank == 0) m = 16'h0200;
      G_CONV:  if (bank == 0) m = 16'h7C00;
      G_CHG:   if (bank == 1) m = 16'h00FF;
      G_SINK:  if (bank == 1) m = 16'h0300;
      G_UVOLT: begin
        if (bank == 2) m = 16'h03FF;
        if (bank == 3) m = 16'h000F;
      end
      G_HICUR: if (bank == 3) m = 16'h0030;
      G_GPIO:  if (bank == 4) m = 16'hFFFF;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pmu_irq_bank.sv
module pmu_irq_bank
  import pmu_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic [W-1:0] live
);
  logic [W-1:0] clr_bits;
  logic [W-1:0] set_bits;

  assign clr_bits = clr_we ? wdata : '0;
  assign set_bits = evt & IMPL;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_src
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)           q <= 1'b0;
          else if (set_bits[i]) q <= 1'b1;
          else if (clr_bits[i]) q <= 1'b0;
        end
        assign status[i] = q;
      end else begin : g_tie
        assign status[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '1;
    else if (mask_we) mask <= wdata;
  end

  assign live = status & ~mask;

  // R4 / R2: a strobe always lands, even against a clearing write.
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_bits)) == $past(set_bits)));

  // R3: written-one bits clear when no strobe competes.
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_bits & ~set_bits)) == '0));

  // R2 / R3: bits not written as one hold their value.
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_bits)) == $past(status & ~clr_bits)));
endmodule

// File: rtl/pmu_irq_summary.sv
module pmu_irq_summary
  import pmu_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] live_flat,
  input  logic             top_we,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] sum_vec,
  output logic [GRP_W-1:0] topmask,
  output logic             irq_n
);
  logic [GRP_W-1:0] gated;
  logic             pend_any;

  generate
    for (genvar g = 0; g < GRP_W; g++) begin : g_grp
      if (g < NUM_GRP) begin : g_used
        logic [NUM_SEC-1:0] hit;
        for (genvar r = 0; r < NUM_SEC; r++) begin : g_bank
          assign hit[r] = |(live_flat[r*REG_W +: REG_W] & grp_bits(g, r));
        end
        assign sum_vec[g] = |hit;
      end else begin : g_none
        assign sum_vec[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      topmask <= '1;
    else if (top_we) topmask <= wdata;
  end

  assign gated    = sum_vec & ~topmask;
  assign pend_any = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~pend_any;
  end

  // R10: the line follows gated pending state one cycle later.
  assert_irq_assert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> !irq_n);
  assert_irq_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |=> irq_n);

  // R9: a fully masked summary keeps the line idle.
  assert_top_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&topmask) |=> irq_n);
endmodule

// File: rtl/pmu_irq_regif.sv
module pmu_irq_regif
  import pmu_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [SRC_W-1:0]  status_flat,
  input  logic [SRC_W-1:0]  mask_flat,
  input  logic [GRP_W-1:0]  sum_vec,
  input  logic [GRP_W-1:0]  topmask,
  output logic [NUM_SEC-1:0] clr_we,
  output logic [NUM_SEC-1:0] mask_we,
  output logic              top_we,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] rd_mux;

  generate
    for (genvar r = 0; r < NUM_SEC; r++) begin : g_dec
      assign clr_we[r]  = we && (addr == (A_STAT0 + ADDR_W'(r)));
      assign mask_we[r] = we && (addr == (A_MASK0 + ADDR_W'(r)));
    end
  endgenerate
  assign top_we = we && (addr == A_TOPMASK);

  always_comb begin
    rd_mux = '0;
    if (addr == A_SUMMARY) rd_mux = sum_vec;
    if (addr == A_TOPMASK) rd_mux = topmask;
    for (int r = 0; r < NUM_SEC; r++) begin
      if (addr == (A_STAT0 + ADDR_W'(r))) rd_mux = status_flat[r*REG_W +: REG_W];
      if (addr == (A_MASK0 + ADDR_W'(r))) rd_mux = mask_flat[r*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end

  // R11: a write touches at most one register.
  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_we, mask_we, top_we}));
endmodule

// File: rtl/pmu_irq_top.sv
module pmu_irq_top
  import pmu_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_n
);
  logic [SRC_W-1:0]   status_flat;
  logic [SRC_W-1:0]   mask_flat;
  logic [SRC_W-1:0]   live_flat;
  logic [NUM_SEC-1:0] clr_we;
  logic [NUM_SEC-1:0] mask_we;
  logic               top_we;
  logic [GRP_W-1:0]   sum_vec;
  logic [GRP_W-1:0]   topmask;

  generate
    for (genvar r = 0; r < NUM_SEC; r++) begin : g_sec
      pmu_irq_bank #(.W(REG_W), .IMPL(impl_bits(r))) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (src_evt[r*REG_W +: REG_W]),
        .clr_we  (clr_we[r]),
        .mask_we (mask_we[r]),
        .wdata   (bus_wdata),
        .status  (status_flat[r*REG_W +: REG_W]),
        .mask    (mask_flat[r*REG_W +: REG_W]),
        .live    (live_flat[r*REG_W +: REG_W])
      );
    end
  endgenerate

  pmu_irq_summary sum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_flat (live_flat),
    .top_we    (top_we),
    .wdata     (bus_wdata),
    .sum_vec   (sum_vec),
    .topmask   (topmask),
    .irq_n     (irq_n)
  );

  pmu_irq_regif regif_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (bus_addr),
    .we          (bus_we),
    .re          (bus_re),
    .status_flat (status_flat),
    .mask_flat   (mask_flat),
    .sum_vec     (sum_vec),
    .topmask     (topmask),
    .clr_we      (clr_we),
    .mask_we     (mask_we),
    .top_we      (top_we),
    .rdata       (bus_rdata)
  );

  // R5: no summary bit without an unmasked latched source behind it.
  assert_sum_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_vec != '0) |-> (|(status_flat & ~mask_flat)));
endmodule

// File: tb/pmu_irq_top_tb.sv
module pmu_irq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] src_evt = '0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq_n;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pmu_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); src_evt[idx] = 1'b1;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);
    for (int b = 0; b < 5; b++) begin
      rd(5'h10 + 5'(b), d); check("R1 bank mask", d, 16'hFFFF);
      rd(5'h08 + 5'(b), d); check("R1 bank status", d, 16'h0000);
    end
    rd(5'h01, d); check("R1 summary mask", d, 16'hFFFF);
    rd(5'h00, d); check("R1 summary", d, 16'h0000);
  endtask

  task automatic t_latch_clear();
    logic [15:0] d;
    pulse(5);
    rd(5'h08, d); check("R2 latch bank0 bit5", d, 16'h0020);
    pulse(15);
    rd(5'h08, d); check("R2 unused bit stays 0", d, 16'h0020);
    pulse(3*16 + 9);
    rd(5'h0B, d); check("R2 unused bank3 bit9", d, 16'h0000);
    wr(5'h08, 16'hFFDF);
    rd(5'h08, d); check("R3 zero write keeps bit", d, 16'h0020);
    wr(5'h08, 16'h0020);
    rd(5'h08, d); check("R3 one write clears", d, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    pulse(1*16 + 3);
    @(negedge clk);
    bus_addr = 5'h09; bus_wdata = 16'h0008; bus_we = 1'b1; src_evt[1*16 + 3] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; src_evt = '0;
    rd(5'h09, d); check("R4 set beats clear", d, 16'h0008);
    wr(5'h09, 16'h0008);
    rd(5'h09, d); check("R4 later clear works", d, 16'h0000);
  endtask

  task automatic t_mask_and_line();
    logic [15:0] d;
    wr(5'h01, 16'h0000);
    pulse(5);
    @(negedge clk);
    check("R5 masked source keeps line high", {15'd0, irq_n}, 16'd1);
    rd(5'h00, d); check("R5 masked source absent from summary", d, 16'h0000);
    rd(5'h08, d); check("R5 masked source still latched", d, 16'h0020);
    wr(5'h10, 16'hFFDF);
    check("R10 one cycle before line", {15'd0, irq_n}, 16'd1);
    @(negedge clk);
    check("R10 line asserted", {15'd0, irq_n}, 16'd0);
    rd(5'h00, d); check("R6 watchdog group bit3", d, 16'h0008);
    repeat (3) @(negedge clk);
    check("R10 line holds", {15'd0, irq_n}, 16'd0);
    wr(5'h08, 16'h0020);
    check("R10 release one cycle later", {15'd0, irq_n}, 16'd0);
    @(negedge clk);
    check("R10 line released", {15'd0, irq_n}, 16'd1);
    wr(5'h10, 16'hFFFF);
  endtask

  task automatic t_groups();
    int bk[14] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 3, 3, 4};
    int bt[14] = '{0, 1, 3, 5, 7, 8, 9, 12, 4, 9, 6, 2, 5, 11};
    int gp[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 10, 11, 12};
    logic [15:0] d;
    for (int b = 0; b < 5; b++) wr(5'h10 + 5'(b), 16'h0000);
    wr(5'h01, 16'h0000);
    for (int i = 0; i < 14; i++) begin
      pulse(bk[i]*16 + bt[i]);
      rd(5'h00, d);
      if (bk[i] == 0)      check("R6 bank0 group", d, 16'(1) << gp[i]);
      else if (gp[i] == 10 || gp[i] == 11) check("R8 uv/hicur group", d, 16'(1) << gp[i]);
      else                 check("R7 bank1/bank4 group", d, 16'(1) << gp[i]);
      wr(5'h08 + 5'(bk[i]), 16'(1) << bt[i]);
    end
    rd(5'h00, d); check("R8 all cleared", d, 16'h0000);
  endtask

  task automatic t_topmask();
    logic [15:0] d;
    wr(5'h01, 16'h0400);
    pulse(3*16 + 1);
    repeat (2) @(negedge clk);
    check("R9 gated group keeps line high", {15'd0, irq_n}, 16'd1);
    rd(5'h00, d); check("R9 summary shows ungated state", d, 16'h0400);
    wr(5'h01, 16'h0000);
    @(negedge clk);
    check("R9 ungating asserts line", {15'd0, irq_n}, 16'd0);
    wr(5'h0B, 16'h0002);
    @(negedge clk);
    check("R10 clear releases line", {15'd0, irq_n}, 16'd1);
    wr(5'h01, 16'hA5A5);
    rd(5'h01, d); check("R11 summary mask readback", d, 16'hA5A5);
    wr(5'h14, 16'h1234);
    rd(5'h14, d); check("R11 bank4 mask readback", d, 16'h1234);
    rd(5'h13, d); check("R11 no cross write bank3 mask", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_clear();
    t_set_wins();
    t_mask_and_line();
    t_groups();
    t_topmask();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule